// File: doc/BRIEF.md
# Clock-Gate Enable Register Bank

This block holds the enable state of a group of system clock gates, a group of peripheral clock gates and a group of interrupt mask bits. None of these states is written directly. Software raises bits by writing ones to a set word and drops bits by writing ones to a clear word. A third word reads the state back. The gate states leave the block as plain enable vectors, for the clock gating cells placed around it.

The block also captures eight readiness flags into a status word. These flags come from the oscillator, the two PLLs, the master clock and four programmable clock outputs. A single level interrupt is raised whenever any captured flag is also enabled in the mask.

The bus is a plain strobed 32-bit register port. It has no valid/ready handshake and never applies back-pressure. A write takes effect on the clock edge where `wr_en` is high. A read strobe loads `rd_data` on its edge, and `rd_data` then holds that value until the next read.

Top module: `clkgate_regbank`

## Requirements
- R1: After reset, only the processor clock gate (system bit 0) is on, all peripheral gates and all interrupt mask bits are 0, `irq` is low and `rd_data` is 0.
- R2: Writing to a set word (system 0x00, peripheral 0x10, interrupt 0x60) turns on every implemented bit that is 1 in the data, from the write edge on.
- R3: Writing to a clear word (system 0x04, peripheral 0x14, interrupt 0x64) turns off every bit that is 1 in the data, from the write edge on.
- R4: Bits written as 0 to a set or clear word keep their previous state. No state changes without a write.
- R5: A read of a readback word (system 0x08, peripheral 0x18, interrupt mask 0x6C) returns the current state on `rd_data` one clock after `rd_en`, and `rd_data` holds that value afterwards.
- R6: Only system bits 0, 1, 2, 4, 8, 10, 11 and 12 exist (mask 0x1D17). The other system bits never set and read as 0. Only interrupt mask bits 0–3 and 8–11 exist (mask 0x0F0F).
- R7: A write to a reserved offset (for example 0x0C) changes nothing. A read of a reserved offset, or of any set or clear word, returns 0.
- R8: The status word at 0x68 carries oscillator stable in bit 0, PLL A locked in bit 1, PLL B locked in bit 2, master clock ready in bit 3 and programmable clock ready 0–3 in bits 8–11. Each input is captured one clock after it changes. All other status bits read as 0.
- R9: `irq` is high exactly when some captured status bit is set and its mask bit is also set. It is a level, with no latching.
- R10: Peripheral bit n of the set, clear and readback words drives `periph_gate_en[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, loaded on the edge where rd_en is high |
| main_osc_ok | input | 1 | Main oscillator stable |
| pll_a_locked | input | 1 | PLL A locked |
| pll_b_locked | input | 1 | PLL B locked |
| mck_ready | input | 1 | Master clock ready |
| pck_ready | input | 4 | Ready flags of programmable clocks 0–3 |
| sys_gate_en | output | 32 | System clock gate enables (unimplemented bits 0) |
| periph_gate_en | output | NPERIPH | Peripheral clock gate enables, bit n for peripheral n |
| irq | output | 1 | Level interrupt |

## Verification
Gate outputs and the mask change on the edge that takes the write strobe, so the bench checks them at the falling edge that follows. A read result lands one edge after `rd_en`, and every readback is sampled half a cycle after that edge, before another read is issued. A status input reaches both the 0x68 word and `irq` one edge after it moves. A mask write reaches `irq` on its own edge. The bench therefore changes status inputs on a falling edge and checks `irq` on the next falling edge.

// File: rtl/cgb_pkg.sv
package cgb_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_SYS_SET  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SYS_CLR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_SYS_RB   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_HOLE     = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_PER_SET  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_PER_CLR  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_PER_RB   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IRQ_SET  = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_IRQ_CLR  = 8'h64;
  localparam logic [ADDR_W-1:0] OFF_FLAGS    = 8'h68;
  localparam logic [ADDR_W-1:0] OFF_IRQ_RB   = 8'h6C;

  // system gates: processor, usb device, master suspend, usb host, four outputs
  localparam logic [DATA_W-1:0] SYS_IMPL  = 32'h0000_1D17;
  localparam logic [DATA_W-1:0] SYS_RESET = 32'h0000_0001;
  // readiness flags: 0..3 core sources, 8..11 programmable clock ready
  localparam logic [DATA_W-1:0] FLAG_IMPL = 32'h0000_0F0F;
endpackage

// File: rtl/cgb_setclr_bank.sv
module cgb_setclr_bank #(
  parameter int           W    = 32,
  parameter logic [W-1:0] IMPL = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] state
);
  logic [W-1:0] set_bits, clr_bits, nxt;

  always_comb begin
    set_bits = set_stb ? (wdata & IMPL) : '0;
    clr_bits = clr_stb ? wdata : '0;
    nxt      = (state | set_bits) & ~clr_bits & IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= RST & IMPL;
    else        state <= nxt;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((state & $past(wdata & IMPL)) == $past(wdata & IMPL)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((state & $past(wdata)) == '0));

  assert_keep_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> ((state & ~$past(wdata)) == ($past(state) & ~$past(wdata))));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(state));
endmodule

// File: rtl/cgb_rdmux.sv
module cgb_rdmux
  import cgb_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] sys_word,
  input  logic [DATA_W-1:0] per_word,
  input  logic [DATA_W-1:0] flag_word,
  input  logic [DATA_W-1:0] mask_word,
  output logic [DATA_W-1:0] rd_word
);
  always_comb begin
    unique case (addr)
      OFF_SYS_RB: rd_word = sys_word;
      OFF_PER_RB: rd_word = per_word;
      OFF_FLAGS:  rd_word = flag_word;
      OFF_IRQ_RB: rd_word = mask_word;
      default:    rd_word = '0;
    endcase
  end
endmodule

// File: rtl/clkgate_regbank.sv
module clkgate_regbank
  import cgb_pkg::*;
#(
  parameter int NPERIPH = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                main_osc_ok,
  input  logic                pll_a_locked,
  input  logic                pll_b_locked,
  input  logic                mck_ready,
  input  logic [3:0]          pck_ready,
  output logic [DATA_W-1:0]   sys_gate_en,
  output logic [NPERIPH-1:0]  periph_gate_en,
  output logic                irq
);
  localparam logic [NPERIPH-1:0] PER_IMPL = '1;

  logic [DATA_W-1:0] mask_q, flag_q, flag_d, rd_word;

  cgb_setclr_bank #(.W(DATA_W), .IMPL(SYS_IMPL), .RST(SYS_RESET)) u_sys (
    .clk(clk), .rst_n(rst_n),
    .set_stb(wr_en && addr == OFF_SYS_SET),
    .clr_stb(wr_en && addr == OFF_SYS_CLR),
    .wdata(wr_data), .state(sys_gate_en));

  cgb_setclr_bank #(.W(NPERIPH), .IMPL(PER_IMPL), .RST('0)) u_per (
    .clk(clk), .rst_n(rst_n),
    .set_stb(wr_en && addr == OFF_PER_SET),
    .clr_stb(wr_en && addr == OFF_PER_CLR),
    .wdata(wr_data[NPERIPH-1:0]), .state(periph_gate_en));

  cgb_setclr_bank #(.W(DATA_W), .IMPL(FLAG_IMPL), .RST('0)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_stb(wr_en && addr == OFF_IRQ_SET),
    .clr_stb(wr_en && addr == OFF_IRQ_CLR),
    .wdata(wr_data), .state(mask_q));

  always_comb begin
    flag_d        = '0;
    flag_d[0]     = main_osc_ok;
    flag_d[1]     = pll_a_locked;
    flag_d[2]     = pll_b_locked;
    flag_d[3]     = mck_ready;
    flag_d[11:8]  = pck_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d & FLAG_IMPL;
  end

  cgb_rdmux u_rd (
    .addr(addr), .sys_word(sys_gate_en), .per_word(DATA_W'(periph_gate_en)),
    .flag_word(flag_q), .mask_word(mask_q), .rd_word(rd_word));

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  assign irq = |(flag_q & mask_q);

  assert_flag_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_q[0] == $past(main_osc_ok) && flag_q[11:8] == $past(pck_ready)));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_hole_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_HOLE) |=> (rd_data == '0));

  assert_read_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_sys_impl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_gate_en & ~SYS_IMPL) == '0);
endmodule

// File: tb/clkgate_regbank_bench.sv
module clkgate_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        main_osc_ok = 1'b0, pll_a_locked = 1'b0, pll_b_locked = 1'b0, mck_ready = 1'b0;
  logic [3:0]  pck_ready = '0;
  logic [31:0] sys_gate_en;
  logic [31:0] periph_gate_en;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  clkgate_regbank u_clkgate_regbank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .main_osc_ok(main_osc_ok),
    .pll_a_locked(pll_a_locked), .pll_b_locked(pll_b_locked), .mck_ready(mck_ready),
    .pck_ready(pck_ready), .sys_gate_en(sys_gate_en), .periph_gate_en(periph_gate_en),
    .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // {is_read, offset, write data, expected read data}
  localparam int NVEC = 20;
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 32'hFFFF_FFFF, 32'h0},           // R2 R6 set all system bits
    {1'b1, 8'h08, 32'h0,         32'h0000_1D17},   // R6 only implemented bits
    {1'b0, 8'h04, 32'h0000_0012, 32'h0},           // R3 clear bits 1,4
    {1'b1, 8'h08, 32'h0,         32'h0000_1D05},   // R3 R4
    {1'b0, 8'h10, 32'h8000_0005, 32'h0},           // R10 peripherals 0,2,31
    {1'b1, 8'h18, 32'h0,         32'h8000_0005},   // R5 R10
    {1'b0, 8'h10, 32'h0000_0100, 32'h0},           // R4 add peripheral 8
    {1'b1, 8'h18, 32'h0,         32'h8000_0105},   // R4
    {1'b0, 8'h14, 32'h8000_0001, 32'h0},           // R3 drop 0 and 31
    {1'b1, 8'h18, 32'h0,         32'h0000_0104},   // R3
    {1'b0, 8'h0C, 32'hFFFF_FFFF, 32'h0},           // R7 reserved write
    {1'b1, 8'h0C, 32'h0,         32'h0},           // R7 reserved read
    {1'b1, 8'h08, 32'h0,         32'h0000_1D05},   // R7 system state untouched
    {1'b1, 8'h00, 32'h0,         32'h0},           // R7 set word reads 0
    {1'b0, 8'h60, 32'h0000_0F0F, 32'h0},           // R2 mask set
    {1'b1, 8'h6C, 32'h0,         32'h0000_0F0F},   // R5
    {1'b0, 8'h64, 32'h0000_0F00, 32'h0},           // R3 mask clear
    {1'b1, 8'h6C, 32'h0,         32'h0000_000F},   // R3
    {1'b0, 8'h60, 32'hF000_0000, 32'h0},           // R6 unimplemented mask bits
    {1'b1, 8'h6C, 32'h0,         32'h0000_000F}    // R6
  };

  initial begin : watchdog
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sys gates", sys_gate_en, 32'h1);
    check("R1 periph gates", periph_gate_en, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    bus_read(8'h6C, rd); check("R1 mask", rd, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][72]) begin
        bus_read(VEC[i][71:64], rd);
        check($sformatf("vector %0d readback", i), rd, VEC[i][31:0]);
      end else begin
        bus_write(VEC[i][71:64], VEC[i][63:32]);
      end
    end

    // R2 R10 gate ports follow the write edge
    check("R2 sys port", sys_gate_en, 32'h0000_1D05);
    check("R10 periph port", periph_gate_en, 32'h0000_0104);
    bus_write(8'h04, 32'h1);
    check("R3 processor gate off", sys_gate_en, 32'h0000_1D04);
    bus_write(8'h14, 32'h0);
    check("R4 zero clear word", periph_gate_en, 32'h0000_0104);

    // R5 rd_data holds after the read
    repeat (3) @(negedge clk);
    check("R5 rd_data held", rd_data, 32'h0000_000F);

    // R8 status capture
    main_osc_ok = 1'b1; pck_ready = 4'b0100;
    @(negedge clk);
    bus_read(8'h68, rd); check("R8 status word", rd, 32'h0000_0401);
    check("R9 irq from osc with mask bit 0", {31'b0, irq}, 32'h1);
    pll_b_locked = 1'b1; mck_ready = 1'b1; pll_a_locked = 1'b1;
    @(negedge clk);
    bus_read(8'h68, rd); check("R8 all core flags", rd, 32'h0000_040F);

    // R9 mask clear drops irq, mask set raises it
    bus_write(8'h64, 32'hFFFF_FFFF);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    bus_write(8'h60, 32'h0000_0400);
    check("R9 irq from pck2", {31'b0, irq}, 32'h1);
    pck_ready = 4'b0000;
    @(negedge clk);
    check("R9 irq level follows flag", {31'b0, irq}, 32'h0);
    pck_ready = 4'b0100;
    @(negedge clk);
    check("R8 R9 one-clock capture", {31'b0, irq}, 32'h1);

    // R7 write to another reserved offset changes nothing
    bus_write(8'h20, 32'hFFFF_FFFF);
    check("R7 sys after reserved write", sys_gate_en, 32'h0000_1D04);
    check("R7 periph after reserved write", periph_gate_en, 32'h0000_0104);
    bus_read(8'h20, rd); check("R7 reserved read", rd, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule